// File: doc/BRIEF.md
# Byte-Parallel CRC-16 Engine

This block keeps a 16-bit cyclic redundancy remainder over a byte stream, using the generator x^16 + x^12 + x^5 + 1. Each accepted byte moves the remainder forward by eight single-bit division steps in one clock. A combinational XOR network does this work, so the bytes cost no extra cycles. Bit 0 of each byte enters the division first. The remainder shifts toward bit 0, and the feedback taps sit at the mirrored positions of the generator (the constant 16'h8408).

A sender clears the engine and feeds it the frame. It then reads the check value through an output byte multiplexer, low half first. A pulse on the append-step input switches the multiplexer to the high half. A receiver clears the engine and feeds it the frame followed by the two check bytes. A zero-remainder flag then reports an intact frame.

Top module: `crc16_byte_engine`

## Requirements
- R1: When `byteValid` is high and `clear` is low, the register takes the value of eight serial steps. Step i (i = 0..7) uses data bit i: feedback = reg[0] XOR dataIn[i], the register shifts right by one, and it is XORed with 16'h8408 when the feedback is 1.
- R2: A high `clear` sets the register to zero on the next edge and selects the low check byte, even while `byteValid` is high.
- R3: With `byteValid` and `clear` both low, the register keeps its value whatever `dataIn` carries.
- R4: `txByte` equals register bits [7:0] while `txHighSel` is 0 and bits [15:8] while it is 1. Any accepted byte returns `txHighSel` to 0.
- R5: A pulse on `appendStep` (with `byteValid` and `clear` low) toggles `txHighSel` on the next edge and leaves the register unchanged.
- R6: `crcZero` is 1 exactly when the register is all zeros.
- R7: After a clear, a frame followed by its own check bytes (low byte first) leaves the register at zero, with `crcZero` high.
- R8: Flipping any single bit of such a frame or of its check bytes leaves `crcZero` low.
- R9: After `rstN` is asserted, the register is zero and `txHighSel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of the remainder, highest priority |
| byteValid | input | 1 | Accept `dataIn` on this edge |
| dataIn | input | 8 | Data byte, bit 0 processed first |
| appendStep | input | 1 | Advance the check-byte multiplexer to the other half |
| crcOut | output | 16 | Current remainder |
| txByte | output | 8 | Check byte selected for appending |
| txHighSel | output | 1 | 1 when `txByte` carries the high half |
| crcZero | output | 1 | Remainder is zero |

## Verification
On every cycle the assertions check that clear forces a zero remainder, that an idle or append-only cycle keeps the remainder, that the multiplexer toggles or returns to the low half as required, and that the zero flag agrees with the byte offered for transmission. Whether the byte update is the correct division is shown only by the bench. The bench compares every update with a bit-serial model computed on its own. The closure of a frame with its appended check bytes, and the detection of every single-bit corruption, are likewise scenario properties that only the bench's frames can show.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  localparam int CRC_W  = 16;
  localparam int BYTE_W = 8;
  // generator x^16 + x^12 + x^5 + 1 with its tap positions mirrored for LSB-first processing
  localparam logic [CRC_W-1:0] POLY_MIRROR = 16'h8408;

  typedef struct packed {
    logic clr;    // zero the remainder
    logic upd;    // absorb one byte
    logic selHi;  // output multiplexer picks the high half
  } crcStrobes_t;
endpackage

// File: rtl/crc16_ctrl.sv
module crc16_ctrl
  import crc16_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        clear,
  input  logic        byteValid,
  input  logic        appendStep,
  output crcStrobes_t strobes
);
  logic selHiQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   selHiQ <= 1'b0;
    else if (clear || byteValid) selHiQ <= 1'b0;
    else if (appendStep)         selHiQ <= ~selHiQ;
  end

  always_comb begin
    strobes.clr   = clear;
    strobes.upd   = byteValid & ~clear;
    strobes.selHi = selHiQ;
  end

  AST_SEL_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (appendStep && !clear && !byteValid) |=> (selHiQ != $past(selHiQ))); // R5
  AST_SEL_LOW_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid || clear) |=> !selHiQ); // R4
endmodule

// File: rtl/crc16_datapath.sv
module crc16_datapath
  import crc16_pkg::*;
#(
  parameter int W  = CRC_W,
  parameter int BW = BYTE_W,
  parameter logic [W-1:0] POLY = POLY_MIRROR
)(
  input  logic          clk,
  input  logic          rstN,
  input  crcStrobes_t   strobes,
  input  logic [BW-1:0] dataIn,
  output logic [W-1:0]  crcQ,
  output logic [BW-1:0] txByte,
  output logic          crcZero
);
  localparam int HALF = W / 2;

  logic [BW-1:0] mTerm;   // register bit n XOR data bit n
  logic [BW-1:0] fbBit;   // feedback of each equivalent serial step
  logic [W-1:0]  fbAcc;   // contribution of all feedback after BW steps
  logic [W-1:0]  crcNext;

  genvar gi;
  generate
    for (gi = 0; gi < BW; gi++) begin : g_mterm
      assign mTerm[gi] = crcQ[gi] ^ dataIn[gi];
    end
  endgenerate

  // Only the feedback part is tracked step by step; the old register simply moves down by BW.
  always_comb begin
    logic [W-1:0] acc;
    acc   = '0;
    fbBit = '0;
    for (int k = 0; k < BW; k++) begin
      fbBit[k] = mTerm[k] ^ acc[0];
      acc      = (acc >> 1) ^ (fbBit[k] ? POLY : '0);
    end
    fbAcc   = acc;
    crcNext = (crcQ >> BW) ^ fbAcc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            crcQ <= '0;
    else if (strobes.clr) crcQ <= '0;
    else if (strobes.upd) crcQ <= crcNext;
  end

  assign txByte  = strobes.selHi ? crcQ[W-1:HALF] : crcQ[HALF-1:0];
  assign crcZero = (crcQ == '0);

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clr |=> (crcQ == '0)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.clr && !strobes.upd) |=> $stable(crcQ)); // R3
endmodule

// File: rtl/crc16_byte_engine.sv
module crc16_byte_engine
  import crc16_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        clear,
  input  logic        byteValid,
  input  logic [7:0]  dataIn,
  input  logic        appendStep,
  output logic [15:0] crcOut,
  output logic [7:0]  txByte,
  output logic        txHighSel,
  output logic        crcZero
);
  crcStrobes_t strobes;

  crc16_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .clear(clear), .byteValid(byteValid),
    .appendStep(appendStep), .strobes(strobes)
  );

  crc16_datapath #(.W(CRC_W), .BW(BYTE_W), .POLY(POLY_MIRROR)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dataIn(dataIn),
    .crcQ(crcOut), .txByte(txByte), .crcZero(crcZero)
  );

  assign txHighSel = strobes.selHi;

  AST_ZERO_FLAG_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    crcZero |-> (txByte == 8'h00)); // R6
endmodule

// File: tb/tb_crc16_byte_engine.sv
`timescale 1ns/1ps
module tb_crc16_byte_engine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clear = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  dataIn = '0;
  logic        appendStep = 1'b0;
  logic [15:0] crcOut;
  logic [7:0]  txByte;
  logic        txHighSel;
  logic        crcZero;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  crc16_byte_engine dut (
    .clk(clk), .rstN(rstN), .clear(clear), .byteValid(byteValid), .dataIn(dataIn),
    .appendStep(appendStep), .crcOut(crcOut), .txByte(txByte),
    .txHighSel(txHighSel), .crcZero(crcZero)
  );

  localparam logic [7:0] VEC [16] = '{8'h00, 8'hFF, 8'h01, 8'h80, 8'h31, 8'h32, 8'h33, 8'hA5,
                                      8'h5A, 8'hC3, 8'h10, 8'h7E, 8'hE7, 8'h08, 8'h96, 8'h4D};
  localparam logic [7:0] FRAME [6] = '{8'h12, 8'h34, 8'hAB, 8'hCD, 8'h00, 8'hF0};

  function automatic logic [15:0] refStep(logic [15:0] c, logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = c[0] ^ d[i];
      c  = {1'b0, c[15:1]};
      if (fb) c = c ^ 16'h8408;
    end
    return c;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sendByte(logic [7:0] d);
    byteValid = 1'b1; dataIn = d;
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  task automatic doClear();
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic [15:0] model;
    logic [15:0] fcrc;
    logic [7:0]  lo, hi;
    logic [7:0]  msg [8];
    repeat (2) @(negedge clk);
    // R9: reset state
    check("R9 reset crc", crcOut, 16'h0000);
    check("R9 reset sel", {15'b0, txHighSel}, 16'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 / R6: table walk against the serial model
    model = '0;
    for (int v = 0; v < 16; v++) begin
      sendByte(VEC[v]);
      model = refStep(model, VEC[v]);
      check("R1 byte update", crcOut, model);
      check("R6 zero flag", {15'b0, crcZero}, {15'b0, model == 16'h0});
    end

    // R3: idle cycles with changing data
    dataIn = 8'hFF;
    @(negedge clk);
    dataIn = 8'h3C;
    repeat (2) @(negedge clk);
    check("R3 hold", crcOut, model);

    // R2: clear beats byteValid
    clear = 1'b1; byteValid = 1'b1; dataIn = 8'hA5;
    @(negedge clk);
    clear = 1'b0; byteValid = 1'b0;
    check("R2 clear priority", crcOut, 16'h0000);
    check("R6 zero after clear", {15'b0, crcZero}, 16'h1);

    // R4 / R5: append multiplexer on a frame
    fcrc = '0;
    for (int i = 0; i < 6; i++) begin
      sendByte(FRAME[i]);
      fcrc = refStep(fcrc, FRAME[i]);
    end
    check("R1 frame crc", crcOut, fcrc);
    check("R4 low byte", {8'h0, txByte}, {8'h0, fcrc[7:0]});
    lo = txByte;
    appendStep = 1'b1;
    @(negedge clk);
    appendStep = 1'b0;
    check("R5 toggled sel", {15'b0, txHighSel}, 16'h1);
    check("R5 crc unchanged", crcOut, fcrc);
    check("R4 high byte", {8'h0, txByte}, {8'h0, fcrc[15:8]});
    hi = txByte;
    appendStep = 1'b1;
    @(negedge clk);
    appendStep = 1'b0;
    check("R5 toggle back", {15'b0, txHighSel}, 16'h0);
    appendStep = 1'b1;
    @(negedge clk);
    appendStep = 1'b0;
    sendByte(8'h55);
    check("R4 byte returns low", {15'b0, txHighSel}, 16'h0);
    check("R2 clear selects low pre", crcOut, refStep(fcrc, 8'h55));

    // R7: frame plus its own check bytes closes to zero
    for (int i = 0; i < 6; i++) msg[i] = FRAME[i];
    msg[6] = lo; msg[7] = hi;
    doClear();
    for (int i = 0; i < 8; i++) sendByte(msg[i]);
    check("R7 closed remainder", crcOut, 16'h0000);
    check("R7 zero flag", {15'b0, crcZero}, 16'h1);

    // R8: every single-bit corruption is flagged
    for (int b = 0; b < 64; b++) begin
      doClear();
      for (int i = 0; i < 8; i++)
        sendByte(msg[i] ^ ((i == b / 8) ? (8'h01 << (b % 8)) : 8'h00));
      check("R8 flipped bit", {15'b0, crcZero}, 16'h0);
    end

    finish();
  end
endmodule